// File: doc/BRIEF.md
# JTAG Host Shift Engine

This block is the host end of a JTAG adapter. A command issuer hands it one of three operations: return the chain's controller to Test-Logic-Reset, shift N instruction bits, or shift N data bits. Shift commands carry the bits for TDI. The engine derives TCK from the system clock through a programmable divider. It drives TMS and TDI and samples TDO. It also produces the TMS navigation itself, so the issuer needs no knowledge of the controller's state graph or of the target's internals.

Every command begins and ends in Run-Test/Idle. A shift walks to the matching shift state, moves the payload, passes through the matching update state so the target loads its holding register, and then parks in Run-Test/Idle again. The captured TDO bits come back least significant bit first, together with a one-cycle completion pulse. A typical use is a device identifier read: a 4-bit instruction load selects the identifier register, and a 32-bit data shift then returns its contents.

Top module: `jtag_shift_host`

## Requirements
- R1: Command code 2'b00 (tap reset) presents TMS=1 on RST_CYCLES consecutive TCK rising edges (default 5) and then TMS=0 on one more rising edge, which leaves the target in Run-Test/Idle.
- R2: Command code 2'b01 (instruction shift) presents TMS 1,1,0,0 on the first four rising edges. It then presents N shift edges, with TMS=0 on all of them except the last, which has TMS=1. Two final edges follow, with TMS=1 and then TMS=0. The target's instruction register therefore updates to the shifted value.
- R3: Command code 2'b10 (data shift) presents TMS 1,0,0 on the first three rising edges. It then presents the same N shift edges and the same 1,0 tail as R2.
- R4: During the shift edges, TDI carries cmd_tdi bit 0 first, then bit 1, and so on, one bit per TCK period. TMS and TDI change only while TCK is low and stay constant across every TCK rising edge and every TCK high phase.
- R5: TDO is sampled at the TCK rising edge of each shift edge. Sample k is placed in rsp_tdo[k], and the bits of rsp_tdo above N-1 read zero.
- R6: Each TCK half period lasts div_half+1 system clock cycles. TCK rests low whenever the engine is not busy.
- R7: busy rises in the cycle after a command is accepted. done is a single-cycle pulse during which busy is already low, and rsp_tdo holds the result from that cycle until the next command.
- R8: A cmd_valid seen while busy is high is ignored. The TMS sequence of the running command is neither lengthened nor altered.
- R9: Command code 2'b11 is reserved and ignored: busy stays low and TCK does not toggle.
- R10: cmd_len encodes N-1, so shifts of 1 bit and of MAX_LEN bits (default 64) are both carried out in full.
- R11: After reset, tck, tms, tdi, busy and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_op | input | 2 | 00 tap reset, 01 instruction shift, 10 data shift, 11 reserved |
| cmd_len | input | $clog2(MAX_LEN) | Shift length minus one |
| cmd_tdi | input | MAX_LEN | Bits to shift out, bit 0 first |
| div_half | input | DIV_W | TCK half period minus one, in system clocks; hold stable while busy |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_tdo | output | MAX_LEN | Captured TDO bits, bit 0 first |
| tck | output | 1 | Test clock to the chain |
| tms | output | 1 | Test mode select to the chain |
| tdi | output | 1 | Test data to the chain |
| tdo | input | 1 | Test data from the chain |

## Verification
The checker watches several properties on every cycle. TMS and TDI must hold steady across each TCK rising edge and through each high phase. TCK must rest low outside a command. done must be a lone pulse that follows busy falling. Whether the TMS route actually takes a controller to the right shift and update states can only be shown by the bench's scenarios, which run a behavioural TAP model with a 4-bit instruction register, an identifier register and a bypass bit. The same holds for the bit order of TDI and TDO, the TCK period under a given divider, the handling of ignored and reserved commands, and the 1-bit and full-length shifts.

// File: rtl/jtag_host_pkg.sv
package jtag_host_pkg;

  typedef enum logic [1:0] {
    OP_TAP_RESET = 2'b00,
    OP_SHIFT_IR  = 2'b01,
    OP_SHIFT_DR  = 2'b10,
    OP_RSVD      = 2'b11
  } host_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RESET,
    PH_PRE,
    PH_SHIFT,
    PH_POST
  } phase_e;

  // Slots spent walking from Run-Test/Idle to the shift state.
  localparam int unsigned IR_PRE_SLOTS = 4;
  localparam int unsigned DR_PRE_SLOTS = 3;
  // Slots from Exit1 through Update back to Run-Test/Idle.
  localparam int unsigned POST_SLOTS   = 2;

endpackage

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             tck,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tck_q, tck_d;
  logic             tick;

  assign tick     = run && (cnt_q == div_half);
  assign rise_evt = tick && !tck_q;
  assign fall_evt = tick && tck_q;
  assign tck      = tck_q;

  always_comb begin
    cnt_d = cnt_q;
    tck_d = tck_q;
    if (!run) begin
      cnt_d = '0;
      tck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      tck_d = ~tck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tck_q <= tck_d;
    end
  end

endmodule

// File: rtl/jtag_tms_seq.sv
module jtag_tms_seq
  import jtag_host_pkg::*;
#(
  parameter int unsigned MAX_LEN    = 64,
  parameter int unsigned RST_CYCLES = 5,
  parameter int unsigned LEN_W      = $clog2(MAX_LEN),
  parameter int unsigned CNT_W      = $clog2(((MAX_LEN > RST_CYCLES) ? MAX_LEN : RST_CYCLES) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             fall_evt,
  output logic             accept,
  output logic             busy,
  output logic             shift_act,
  output logic [CNT_W-1:0] slot_cnt,
  output logic             tms,
  output logic             done
);

  phase_e           phase_q, phase_d;
  host_op_e         op_q, op_d, op_in;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] pre_last;
  logic [CNT_W-1:0] len_ext;

  localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_CYCLES);
  localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(POST_SLOTS - 1);
  localparam logic [CNT_W-1:0] IR_LAST   = CNT_W'(IR_PRE_SLOTS - 1);
  localparam logic [CNT_W-1:0] DR_LAST   = CNT_W'(DR_PRE_SLOTS - 1);

  assign op_in    = host_op_e'(cmd_op);
  assign accept   = cmd_valid && (phase_q == PH_IDLE) && (op_in != OP_RSVD);
  assign pre_last = (op_q == OP_SHIFT_IR) ? IR_LAST : DR_LAST;
  assign len_ext  = CNT_W'(len_q);

  // Next-state logic: a slot advances on each falling TCK edge.
  always_comb begin
    phase_d = phase_q;
    op_d    = op_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    done_d  = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (accept) begin
        op_d    = op_in;
        len_d   = cmd_len;
        cnt_d   = '0;
        phase_d = (op_in == OP_TAP_RESET) ? PH_RESET : PH_PRE;
      end
    end else if (fall_evt) begin
      unique case (phase_q)
        PH_RESET: begin
          if (cnt_q == RST_LAST) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_PRE: begin
          if (cnt_q == pre_last) begin
            phase_d = PH_SHIFT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_SHIFT: begin
          if (cnt_q == len_ext) begin
            phase_d = PH_POST;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_POST: begin
          if (cnt_q == POST_LAST) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  // TMS value for the current slot.
  always_comb begin
    unique case (phase_q)
      PH_RESET: tms = (cnt_q != RST_LAST);
      PH_PRE:   tms = (op_q == OP_SHIFT_IR) ? (cnt_q < CNT_W'(2)) : (cnt_q == '0);
      PH_SHIFT: tms = (cnt_q == len_ext);
      PH_POST:  tms = (cnt_q == '0);
      default:  tms = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_TAP_RESET;
      cnt_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      done_q  <= done_d;
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign shift_act = (phase_q == PH_SHIFT);
  assign slot_cnt  = cnt_q;
  assign done      = done_q;

endmodule

// File: rtl/jtag_shift_path.sv
module jtag_shift_path #(
  parameter int unsigned MAX_LEN = 64,
  parameter int unsigned LEN_W   = $clog2(MAX_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [MAX_LEN-1:0] load_data,
  input  logic               shift_act,
  input  logic [LEN_W-1:0]   bit_idx,
  input  logic               rise_evt,
  input  logic               fall_evt,
  input  logic               tdo,
  output logic               tdi,
  output logic [MAX_LEN-1:0] cap
);

  logic [MAX_LEN-1:0] sr_q, sr_d;
  logic [MAX_LEN-1:0] cap_q, cap_d;
  logic               sr_en, cap_en;

  assign sr_en  = load || (fall_evt && shift_act);
  assign cap_en = load || (rise_evt && shift_act);

  always_comb begin
    sr_d = sr_q;
    if (load) begin
      sr_d = load_data;
    end else if (fall_evt && shift_act) begin
      sr_d = {1'b0, sr_q[MAX_LEN-1:1]};
    end
  end

  always_comb begin
    cap_d = cap_q;
    if (load) begin
      cap_d = '0;
    end else if (rise_evt && shift_act) begin
      cap_d[bit_idx] = tdo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_en) begin
      cap_q <= cap_d;
    end
  end

  assign tdi = shift_act ? sr_q[0] : 1'b0;
  assign cap = cap_q;

endmodule

// File: rtl/jtag_shift_host.sv
module jtag_shift_host
  import jtag_host_pkg::*;
#(
  parameter int unsigned MAX_LEN    = 64,
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned RST_CYCLES = 5,
  parameter int unsigned LEN_W      = $clog2(MAX_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [LEN_W-1:0]   cmd_len,
  input  logic [MAX_LEN-1:0] cmd_tdi,
  input  logic [DIV_W-1:0]   div_half,
  output logic               busy,
  output logic               done,
  output logic [MAX_LEN-1:0] rsp_tdo,
  output logic               tck,
  output logic               tms,
  output logic               tdi,
  input  logic               tdo
);

  localparam int unsigned CNT_W =
    $clog2(((MAX_LEN > RST_CYCLES) ? MAX_LEN : RST_CYCLES) + 1);

  logic             rst_meta_q, rst_sync_q;
  logic             accept, shift_act, rise_evt, fall_evt;
  logic [CNT_W-1:0] slot_cnt;

  // Reset asserts asynchronously, releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  jtag_tms_seq #(
    .MAX_LEN    (MAX_LEN),
    .RST_CYCLES (RST_CYCLES),
    .LEN_W      (LEN_W),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_len   (cmd_len),
    .fall_evt  (fall_evt),
    .accept    (accept),
    .busy      (busy),
    .shift_act (shift_act),
    .slot_cnt  (slot_cnt),
    .tms       (tms),
    .done      (done)
  );

  jtag_tck_gen #(
    .DIV_W (DIV_W)
  ) u_tck (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .run      (busy),
    .div_half (div_half),
    .tck      (tck),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  jtag_shift_path #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W)
  ) u_path (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load      (accept),
    .load_data (cmd_tdi),
    .shift_act (shift_act),
    .bit_idx   (slot_cnt[LEN_W-1:0]),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .tdo       (tdo),
    .tdi       (tdi),
    .cap       (rsp_tdo)
  );

endmodule

// File: rtl/jtag_shift_host_chk.sv
module jtag_shift_host_chk (
  input logic clk,
  input logic rst_n,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic busy,
  input logic done
);

  AST_TCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck); // R6

  AST_TMS_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> $stable(tms)); // R4

  AST_TDI_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> $stable(tdi)); // R4

  AST_HOLD_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi))); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7

endmodule

bind jtag_shift_host jtag_shift_host_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tck   (tck),
  .tms   (tms),
  .tdi   (tdi),
  .busy  (busy),
  .done  (done)
);

// File: tb/jtag_shift_host_bench.sv
module jtag_shift_host_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN    = 64;
  localparam int DIV_W      = 8;
  localparam int LEN_W      = 6;
  localparam logic [31:0] IDCODE_VAL = 32'h1A2B_3C5D;
  localparam logic [3:0]  IR_IDCODE  = 4'b0001;
  localparam logic [3:0]  IR_BYPASS  = 4'b1111;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cmd_valid = 1'b0;
  logic [1:0]         cmd_op = 2'b00;
  logic [LEN_W-1:0]   cmd_len = '0;
  logic [MAX_LEN-1:0] cmd_tdi = '0;
  logic [DIV_W-1:0]   div_half = 8'd1;
  logic               busy, done, tck, tms, tdi;
  logic [MAX_LEN-1:0] rsp_tdo;
  logic               tdo_m = 1'b0;

  int tests_run = 0;
  int tests_failed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_shift_host #(
    .MAX_LEN (MAX_LEN),
    .DIV_W   (DIV_W),
    .RST_CYCLES (5)
  ) u_jtag_shift_host (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
    .cmd_len (cmd_len), .cmd_tdi (cmd_tdi), .div_half (div_half),
    .busy (busy), .done (done), .rsp_tdo (rsp_tdo),
    .tck (tck), .tms (tms), .tdi (tdi), .tdo (tdo_m)
  );

  // Behavioural TAP controller with a 4-bit IR, identifier and bypass.
  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SDRS, S_CDR, S_SDR, S_E1DR, S_PDR, S_E2DR, S_UDR,
    S_SIRS, S_CIR, S_SIR, S_E1IR, S_PIR, S_E2IR, S_UIR
  } tap_e;

  tap_e        st = S_TLR;
  logic [3:0]  m_ir = IR_IDCODE;
  logic [3:0]  m_ir_sr = '0;
  logic [31:0] m_dr_sr = '0;
  logic        m_byp = 1'b0;
  logic        saw_tlr = 1'b0;

  function automatic tap_e tap_next(tap_e s, logic m);
    case (s)
      S_TLR:  return m ? S_TLR  : S_RTI;
      S_RTI:  return m ? S_SDRS : S_RTI;
      S_SDRS: return m ? S_SIRS : S_CDR;
      S_CDR:  return m ? S_E1DR : S_SDR;
      S_SDR:  return m ? S_E1DR : S_SDR;
      S_E1DR: return m ? S_UDR  : S_PDR;
      S_PDR:  return m ? S_E2DR : S_PDR;
      S_E2DR: return m ? S_UDR  : S_SDR;
      S_UDR:  return m ? S_SDRS : S_RTI;
      S_SIRS: return m ? S_TLR  : S_CIR;
      S_CIR:  return m ? S_E1IR : S_SIR;
      S_SIR:  return m ? S_E1IR : S_SIR;
      S_E1IR: return m ? S_UIR  : S_PIR;
      S_PIR:  return m ? S_E2IR : S_PIR;
      S_E2IR: return m ? S_UIR  : S_SIR;
      default: return m ? S_SDRS : S_RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    case (st)
      S_TLR: begin m_ir <= IR_IDCODE; saw_tlr <= 1'b1; end
      S_CIR: m_ir_sr <= 4'b0101;
      S_SIR: m_ir_sr <= {tdi, m_ir_sr[3:1]};
      S_UIR: m_ir <= m_ir_sr;
      S_CDR: if (m_ir == IR_IDCODE) m_dr_sr <= IDCODE_VAL; else m_byp <= 1'b0;
      S_SDR: if (m_ir == IR_IDCODE) m_dr_sr <= {tdi, m_dr_sr[31:1]}; else m_byp <= tdi;
      default: ;
    endcase
    st <= tap_next(st, tms);
  end

  always @(negedge tck) begin
    if (st == S_SIR) tdo_m <= m_ir_sr[0];
    else if (st == S_SDR) tdo_m <= (m_ir == IR_IDCODE) ? m_dr_sr[0] : m_byp;
    else tdo_m <= 1'b0;
  end

  // TMS trace at every TCK rising edge.
  logic [255:0] tr_vec = '0;
  int           tcnt = 0;
  always @(posedge tck) begin
    if (tcnt < 256) tr_vec[tcnt] <= tms;
    tcnt <= tcnt + 1;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] shift_route(input logic is_ir, input int n, output int len);
    logic [255:0] v = '0;
    int p = 0;
    if (is_ir) begin v[0] = 1; v[1] = 1; p = 4; end
    else begin v[0] = 1; p = 3; end
    for (int i = 0; i < n; i++) begin v[p] = (i == n-1); p++; end
    v[p] = 1; p++;
    v[p] = 0; p++;
    len = p;
    return v;
  endfunction

  task automatic chk_trace(input string req, input logic [255:0] exp, input int len);
    logic [255:0] mask = (256'b1 << len) - 256'b1;
    chk(tcnt == len, req, "tck edge count", 64'(tcnt), 64'(len));
    chk(((tr_vec ^ exp) & mask) == '0, req, "tms route",
        tr_vec[63:0], exp[63:0]);
  endtask

  task automatic issue(input logic [1:0] op, input int len_m1, input logic [MAX_LEN-1:0] data);
    @(negedge clk);
    tcnt = 0;
    cmd_op = op; cmd_len = LEN_W'(len_m1); cmd_tdi = data; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R7", "busy after accept", 64'(busy), 64'd1);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R7", "done seen", 64'(done), 64'd1);
    chk(busy == 1'b0, "R7", "busy low with done", 64'(busy), 64'd0);
    chk(tck == 1'b0, "R6", "tck low at done", 64'(tck), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done single cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset_state();
    chk({tck, tms, tdi, busy, done} == 5'b0, "R11", "outputs after reset",
        64'({tck, tms, tdi, busy, done}), 64'd0);
  endtask

  task automatic t_tap_reset();
    logic [255:0] e = 256'h1F;
    saw_tlr = 1'b0;
    issue(2'b00, 0, '0);
    wait_done();
    chk_trace("R1", e, 6);
    chk(saw_tlr == 1'b1, "R1", "passed Test-Logic-Reset", 64'(saw_tlr), 64'd1);
    chk(st == S_RTI, "R1", "parked in idle", 64'(st), 64'(S_RTI));
  endtask

  task automatic t_load_ir(input logic [3:0] code);
    int len;
    logic [255:0] e = shift_route(1'b1, 4, len);
    issue(2'b01, 3, MAX_LEN'(code));
    wait_done();
    chk_trace("R2", e, len);
    chk(m_ir == code, "R2", "instruction updated", 64'(m_ir), 64'(code));
    chk(rsp_tdo == 64'h5, "R5", "IR capture bits", rsp_tdo, 64'h5);
    chk(st == S_RTI, "R2", "idle after IR", 64'(st), 64'(S_RTI));
  endtask

  task automatic t_read_id();
    int len;
    logic [255:0] e = shift_route(1'b0, 32, len);
    t_load_ir(IR_IDCODE);
    issue(2'b10, 31, '0);
    wait_done();
    chk_trace("R3", e, len);
    chk(rsp_tdo == {32'h0, IDCODE_VAL}, "R5", "identifier read", rsp_tdo, {32'h0, IDCODE_VAL});
  endtask

  task automatic t_bypass_min();
    int len;
    logic [255:0] e = shift_route(1'b0, 1, len);
    t_load_ir(IR_BYPASS);
    issue(2'b10, 0, 64'h1);
    wait_done();
    chk_trace("R10", e, len);
    chk(rsp_tdo == '0, "R10", "1-bit bypass result", rsp_tdo, 64'h0);
    chk(m_byp == 1'b1, "R4", "tdi bit 0 reached target", 64'(m_byp), 64'd1);
  endtask

  task automatic t_bypass_max();
    logic [63:0] pat = 64'hC3A5_0F96_7E18_B24D;
    int len;
    logic [255:0] e = shift_route(1'b0, 64, len);
    issue(2'b10, 63, pat);
    wait_done();
    chk_trace("R10", e, len);
    chk(rsp_tdo == {pat[62:0], 1'b0}, "R4", "64-bit bypass order", rsp_tdo, {pat[62:0], 1'b0});
  endtask

  task automatic t_tck_period();
    time t0, t1;
    div_half = 8'd3;
    issue(2'b00, 0, '0);
    @(posedge tck); t0 = $time;
    @(posedge tck); t1 = $time;
    chk((t1 - t0) == 8 * CLK_PERIOD, "R6", "tck period div 3", 64'(t1 - t0), 64'(8 * CLK_PERIOD));
    wait_done();
    repeat (5) @(negedge clk);
    chk(tck == 1'b0, "R6", "tck rests low", 64'(tck), 64'd0);
    div_half = 8'd1;
  endtask

  task automatic t_busy_ignore();
    int len;
    logic [255:0] e = shift_route(1'b0, 8, len);
    issue(2'b10, 7, 64'hA5);
    saw_tlr = 1'b0;
    repeat (6) @(negedge clk);
    cmd_op = 2'b00; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    chk_trace("R8", e, len);
    chk(saw_tlr == 1'b0, "R8", "no reset performed", 64'(saw_tlr), 64'd0);
    chk(rsp_tdo == 64'h4A, "R8", "running shift result", rsp_tdo, 64'h4A);
  endtask

  task automatic t_reserved();
    int seen_busy = 0;
    @(negedge clk);
    tcnt = 0;
    cmd_op = 2'b11; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (busy) seen_busy++;
      @(negedge clk);
    end
    chk(seen_busy == 0, "R9", "reserved code busy", 64'(seen_busy), 64'd0);
    chk(tcnt == 0, "R9", "reserved code tck edges", 64'(tcnt), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_tap_reset();
    t_read_id();
    t_bypass_min();
    t_bypass_max();
    t_tck_period();
    t_load_ir(IR_BYPASS);
    t_busy_ignore();
    t_reserved();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule